// File: doc/BRIEF.md
# Hysteretic Digital PLL Lock Detector

This block decides whether a phase-locked loop has settled. Each phase-detector cycle produces an UP pulse and a DOWN pulse. A fast sampling clock measures how wide each pulse is. The wider of the two, counted in sampling-clock periods, is taken as the phase error of that cycle. A strobe marks the last sampling clock of each phase-detector cycle. The error is judged once, at that strobe.

The lock flag is active high. It goes high only after a run of consecutive cycles whose error is below a small threshold. A mode input sets the run length: three cycles when low, five when high. Once the flag is high, it falls only when a cycle's error exceeds a second, larger threshold. Errors between the two thresholds leave it alone. This gap gives the detector hysteresis, so small jitter does not make the flag chatter. The mode bit is normally driven from a field of the reference-divider configuration.

Top module: `pll_lock_monitor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the lock flag and discards any partial run, so a full run of good cycles is needed again afterwards.
- R2: The error of a cycle is the larger of two counts: clocks with `up_i` high and clocks with `dn_i` high. Each count covers every clock since the previous strobe, including the strobe clock itself.
- R3: With `long_mode_i` = 0 and the flag low, `lock_o` rises on the clock edge that samples the third consecutive strobe whose error is below `GOOD_TICKS` (3).
- R4: With `long_mode_i` = 1 and the flag low, five consecutive strobes with error below `GOOD_TICKS` are needed; after four the flag is still low.
- R5: While the flag is low, a strobe whose error is `GOOD_TICKS` or more restarts the run from zero and keeps the flag low.
- R6: While the flag is high, a strobe whose error lies between `GOOD_TICKS` and `BAD_TICKS` (5) inclusive leaves the flag high.
- R7: While the flag is high, a strobe whose error exceeds `BAD_TICKS` clears the flag on that edge. A fresh full run is then required.
- R8: Pulse-width counts saturate at 2^`CNT_W`-1 (63). A very long pulse counts as a large error and never wraps around to a small one.
- R9: `lock_o` changes only on clock edges where the strobe or reset is sampled high.
- R10: `long_mode_i` is read at each strobe. If it is lowered partway through a run, the cycles already counted still count toward the shorter run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| up_i | input | 1 | UP pulse from the phase-frequency detector |
| dn_i | input | 1 | DOWN pulse from the phase-frequency detector |
| cyc_strobe_i | input | 1 | High on the final sampling clock of each phase-detector cycle |
| long_mode_i | input | 1 | 0: three-cycle lock run, 1: five-cycle lock run |
| lock_o | output | 1 | Lock flag, active high |

## Verification
The bench targets each edge where a slightly wrong design would give a different flag:

- **Thresholds.** An error exactly at `GOOD_TICKS` must break a run. An error exactly at `BAD_TICKS` must not drop lock. An off-by-one comparison would lock too early or unlock on mild error.
- **Pulse ending on the strobe clock.** A design that skips the strobe clock's sample would see that pulse as one period shorter, count the cycle as good, and lock too soon.
- **Long pulse.** A pulse longer than the counter range exposes wrap-around: a wrapping counter reads a small error and keeps lock.
- **Mode and reset mid-run.** Switching the mode partway through a run, and resetting partway through a run, catch designs that clear or compare the run count wrongly.

A reference model predicts the flag on every clock, so a flag that moves between strobes is caught as well.

// File: rtl/pll_lock_monitor.sv
`timescale 1ns/1ps
module pll_lock_monitor #(
  parameter int CNT_W      = 6,
  parameter int GOOD_TICKS = 3,
  parameter int BAD_TICKS  = 5,
  parameter int SHORT_RUN  = 3,
  parameter int LONG_RUN   = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic up_i,
  input  logic dn_i,
  input  logic cyc_strobe_i,
  input  logic long_mode_i,
  output logic lock_o
);
  localparam int RUN_W = $clog2(LONG_RUN + 1);
  localparam logic [CNT_W-1:0] SAT    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] GOOD_L = CNT_W'(GOOD_TICKS);
  localparam logic [CNT_W-1:0] BAD_L  = CNT_W'(BAD_TICKS);
  localparam logic [RUN_W-1:0] SHORT_L = RUN_W'(SHORT_RUN);
  localparam logic [RUN_W-1:0] LONG_L  = RUN_W'(LONG_RUN);

  logic [CNT_W-1:0] up_w, dn_w;
  logic [RUN_W-1:0] run;
  logic             lock_q;

  wire [CNT_W-1:0] up_nxt = (up_w == SAT) ? up_w : up_w + {{(CNT_W-1){1'b0}}, up_i};
  wire [CNT_W-1:0] dn_nxt = (dn_w == SAT) ? dn_w : dn_w + {{(CNT_W-1){1'b0}}, dn_i};
  wire [CNT_W-1:0] err    = (up_nxt > dn_nxt) ? up_nxt : dn_nxt;
  wire             good   = err < GOOD_L;
  wire             bad    = err > BAD_L;
  wire [RUN_W-1:0] need   = long_mode_i ? LONG_L : SHORT_L;
  wire [RUN_W-1:0] run_inc = run + 1'b1;
  wire             hit    = good && (run_inc >= need);

  always_ff @(posedge clk) begin
    if (rst) begin
      up_w <= '0;
      dn_w <= '0;
    end else if (cyc_strobe_i) begin
      up_w <= '0;
      dn_w <= '0;
    end else begin
      up_w <= up_nxt;
      dn_w <= dn_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      run    <= '0;
    end else if (cyc_strobe_i) begin
      if (lock_q) begin
        if (bad) lock_q <= 1'b0;
        run <= '0;
      end else if (!good) begin
        run <= '0;
      end else if (hit) begin
        lock_q <= 1'b1;
        run    <= '0;
      end else begin
        run <= run_inc;
      end
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/pll_lock_monitor_chk.sv
`timescale 1ns/1ps
module pll_lock_monitor_chk #(
  parameter int GOOD_TICKS = 3,
  parameter int BAD_TICKS  = 5
) (
  input logic clk,
  input logic rst,
  input logic up_i,
  input logic dn_i,
  input logic cyc_strobe_i,
  input logic lock_o
);
  int uc, dc, ue, de, e;
  always_comb begin
    ue = uc + (up_i ? 1 : 0);
    de = dc + (dn_i ? 1 : 0);
    e  = (ue > de) ? ue : de;
  end
  always_ff @(posedge clk) begin
    if (rst || cyc_strobe_i) begin
      uc <= 0;
      dc <= 0;
    end else begin
      uc <= ue;
      dc <= de;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> !lock_o);
  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_strobe_i |=> $stable(lock_o));
  // R5
  no_early_chk: assert property (@(posedge clk) disable iff (rst)
    (!lock_o && cyc_strobe_i && e >= GOOD_TICKS) |=> !lock_o);
  // R6
  keep_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_o && cyc_strobe_i && e <= BAD_TICKS) |=> lock_o);
  // R7
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_o && cyc_strobe_i && e > BAD_TICKS) |=> !lock_o);
endmodule

bind pll_lock_monitor pll_lock_monitor_chk #(
  .GOOD_TICKS(GOOD_TICKS), .BAD_TICKS(BAD_TICKS)
) u_chk (
  .clk(clk), .rst(rst), .up_i(up_i), .dn_i(dn_i),
  .cyc_strobe_i(cyc_strobe_i), .lock_o(lock_o)
);

// File: tb/pll_lock_monitor_tb_top.sv
`timescale 1ns/1ps
module pll_lock_monitor_tb_top;
  localparam int SATV = 63;
  logic clk = 1'b0;
  logic rst = 1'b1, up = 1'b0, dn = 1'b0, stb = 1'b0, mode = 1'b0;
  logic lock;
  int total = 0, bad = 0, cycles = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  pll_lock_monitor dut_i (
    .clk(clk), .rst(rst), .up_i(up), .dn_i(dn),
    .cyc_strobe_i(stb), .long_mode_i(mode), .lock_o(lock)
  );

  // reference model
  bit armed = 0;
  int m_u = 0, m_d = 0, m_run = 0;
  bit m_lock = 0;
  always @(posedge clk) begin
    int nu, nd, e, need;
    cycles++;
    if (rst) begin
      armed = 1; m_lock = 0; m_run = 0; m_u = 0; m_d = 0;
    end else begin
      nu = m_u + (up ? 1 : 0); if (nu > SATV) nu = SATV;
      nd = m_d + (dn ? 1 : 0); if (nd > SATV) nd = SATV;
      if (stb) begin
        e = (nu > nd) ? nu : nd;
        need = mode ? 5 : 3;
        if (m_lock) begin
          if (e > 5) m_lock = 0;
        end else if (e < 3) begin
          m_run++;
          if (m_run >= need) begin m_lock = 1; m_run = 0; end
        end else m_run = 0;
        m_u = 0; m_d = 0;
      end else begin
        m_u = nu; m_d = nd;
      end
    end
  end

  always @(negedge clk) if (armed) begin
    total++;
    if (lock !== m_lock) begin
      bad++;
      $display("FAIL %s per-clock: lock=%b expected %b at %0t", cur_req, lock, m_lock, $time);
    end
  end

  task automatic check(input string req, input logic exp);
    total++;
    if (lock !== exp) begin
      bad++;
      $display("FAIL %s: lock=%b expected %b at %0t", req, lock, exp, $time);
    end
  endtask

  // one phase-detector cycle; overlap puts the strobe on the last pulse clock
  task automatic pfd(input int uw, input int dw, input bit overlap);
    int w = (uw > dw) ? uw : dw;
    int len = overlap ? ((w < 1) ? 1 : w) : w + 1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      up = (i < uw); dn = (i < dw); stb = (i == len - 1);
    end
    @(negedge clk);
    up = 0; dn = 0; stb = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst = 0;

    cur_req = "R3";
    pfd(2, 0, 0); pfd(0, 1, 0); check("R3", 1'b0);
    pfd(0, 0, 0); check("R3", 1'b1);

    cur_req = "R6";
    pfd(4, 1, 0); check("R6", 1'b1);
    pfd(0, 5, 0); check("R6", 1'b1);
    cur_req = "R7";
    pfd(6, 0, 0); check("R7", 1'b0);
    pfd(1, 1, 0); pfd(1, 1, 0); check("R7", 1'b0);
    pfd(1, 1, 0); check("R7", 1'b1);
    pfd(7, 0, 0); check("R7", 1'b0);

    cur_req = "R5";
    pfd(1, 0, 0); pfd(2, 2, 0); pfd(3, 0, 0); check("R5", 1'b0);
    pfd(0, 0, 0); pfd(0, 0, 0); check("R5", 1'b0);
    pfd(0, 0, 0); check("R5", 1'b1);

    cur_req = "R2";
    do_reset();
    pfd(1, 4, 0); pfd(0, 0, 0); pfd(0, 0, 0); check("R2", 1'b0);
    do_reset();
    pfd(0, 0, 0); pfd(0, 0, 0); pfd(3, 0, 1); check("R2", 1'b0);
    pfd(2, 0, 1); pfd(0, 2, 1); check("R2", 1'b0);
    pfd(1, 0, 1); check("R2", 1'b1);

    cur_req = "R8";
    pfd(66, 0, 0); check("R8", 1'b0);
    pfd(0, 0, 0); pfd(0, 0, 0); pfd(0, 66, 1); check("R8", 1'b0);

    cur_req = "R4";
    do_reset(); mode = 1;
    for (int k = 0; k < 4; k++) pfd(1, 0, 0);
    check("R4", 1'b0);
    pfd(0, 0, 0); check("R4", 1'b1);

    cur_req = "R1";
    do_reset(); check("R1", 1'b0);
    mode = 0;
    pfd(0, 0, 0); pfd(0, 0, 0); do_reset();
    pfd(0, 0, 0); check("R1", 1'b0);
    pfd(0, 0, 0); check("R1", 1'b0);
    pfd(0, 0, 0); check("R1", 1'b1);

    cur_req = "R10";
    do_reset(); mode = 1;
    pfd(0, 0, 0); pfd(0, 0, 0); pfd(0, 0, 0); check("R10", 1'b0);
    mode = 0;
    pfd(0, 0, 0); check("R10", 1'b1);

    cur_req = "R9";
    repeat (10) @(negedge clk);
    check("R9", 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    bad++; total++;
    $display("FAIL watchdog: cycles=%0d expected completion", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule